// File: doc/BRIEF.md
# Minimum energy point search controller

This controller searches for the supply voltage code at which a digital load spends the least energy per operation. It drives a code word to an external dc–dc converter, which produces a supply proportional to that code as a fraction of a fixed battery voltage. With the defaults, one code step stands for 50 mV, and the allowed codes 4 to 10 span 0.2 V to 0.5 V. No absolute voltage is ever needed. For every code it tries, the controller waits a programmable settling time. It then asks a separate sensing unit for a measurement. The unit answers with a done strobe and a raw operation count N, which is the number of clocks the load ran before the supply drooped by a fixed amount. Energy per operation is proportional to V/N, where V is the code.

The search is a hill descent over a convex curve. The controller first measures a baseline at the current code, then probes one code lower. If the probe fails to lower the energy, it probes one code above the starting point instead. Once a probe improves, that direction is fixed and the code keeps moving while readings keep falling. The first reading that does not improve ends the search. The last improving code is then driven again and reported as the result, with a done flag.

Top module: `mep_search`

## Requirements
- R1: After reset, `vcode` and `mep_code` equal INIT_CODE (7), and `meas_req` and `done` are low.
- R2: A `start` pulse accepted while idle or done first measures at the unchanged code. It then steps one code down, unless the code sits at CODE_MIN.
- R3: `meas_req` first goes high exactly settle_len+1 clock edges after the edge that accepted `start` or `meas_done`. It stays high, with `vcode` held, until `meas_done` is sampled.
- R4: A reading (V, N) counts as lower energy than the best (Vb, Nb) only if V·Nb < Vb·N, where V is the code measured. An equal energy is not an improvement.
- R5: If the first downward probe does not improve, the code jumps to start+1 and is measured. If that fails too, or start+1 would pass CODE_MAX, the result is the start code.
- R6: Once a probe improves, steps of exactly one code continue in that direction while each reading improves. The first non-improving reading ends the search at the previous code, and `vcode` returns to it.
- R7: `vcode` never leaves [CODE_MIN, CODE_MAX]. A search that is still improving when it reaches a limit ends at that limit.
- R8: On completion, `done` is high, `meas_req` is low, and `mep_code` and `vcode` both hold the result. A new `start` clears `done` and searches from the current code.
- R9: `start` has no effect while a search is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (accepted only when idle or done) |
| settle_len | input | SETTLE_W | Settling cycles before each measurement request |
| meas_done | input | 1 | Sensing unit has a result |
| meas_count | input | CNT_W | Operations counted before the fixed droop |
| vcode | output | CODE_W | Supply code to the converter |
| meas_req | output | 1 | Measurement request, held until done |
| done | output | 1 | Search finished |
| mep_code | output | CODE_W | Code found to have minimum energy |

## Verification
The search is run against a family of parabolic count curves whose minimum is swept across every code and beyond both limits. This separates the downward walk, the reversal and the immediate stop. A curve with equal energy at every code shows that ties are not treated as improvements. Curves that fall steadily toward either limit exercise clamping, including searches that start already at a limit. Settling length and sensor latency vary from search to search, and a stray `start` during measurement checks that an active search cannot be restarted.

// File: rtl/mep_pkg.sv
package mep_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_MEAS, ST_DONE} mep_state_e;
  typedef enum logic [1:0] {PH_BASE, PH_FIRST, PH_REV, PH_RUN} mep_phase_e;

  // Energy per operation is proportional to V/N. Candidate beats best when
  // cand_v/cand_n < best_v/best_n, evaluated without division.
  function automatic logic lower_energy(input logic [31:0] cand_v, input logic [31:0] cand_n,
                                        input logic [31:0] best_v, input logic [31:0] best_n);
    logic [63:0] lhs;
    logic [63:0] rhs;
    lhs = 64'(cand_v) * 64'(best_n);
    rhs = 64'(best_v) * 64'(cand_n);
    return lhs < rhs;
  endfunction

endpackage

// File: rtl/mep_settle_timer.sv
module mep_settle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: a running settle count drops by one each cycle
  assert_timer_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/mep_energy_cmp.sv
module mep_energy_cmp #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12
) (
  input  logic [CODE_W-1:0] cand_v,
  input  logic [CNT_W-1:0]  cand_n,
  input  logic [CODE_W-1:0] best_v,
  input  logic [CNT_W-1:0]  best_n,
  output logic              lower
);
  assign lower = mep_pkg::lower_energy(32'(cand_v), 32'(cand_n), 32'(best_v), 32'(best_n));
endmodule

// File: rtl/mep_search.sv
module mep_search #(
  parameter int CODE_W    = 4,
  parameter int CNT_W     = 12,
  parameter int SETTLE_W  = 4,
  parameter int CODE_MIN  = 4,
  parameter int CODE_MAX  = 10,
  parameter int INIT_CODE = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                meas_done,
  input  logic [CNT_W-1:0]    meas_count,
  output logic [CODE_W-1:0]   vcode,
  output logic                meas_req,
  output logic                done,
  output logic [CODE_W-1:0]   mep_code
);
  import mep_pkg::*;

  localparam logic [CODE_W-1:0] LO   = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] HI   = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] INIT = CODE_W'(INIT_CODE);

  mep_state_e          state;
  mep_phase_e          phase, nxt_phase;
  logic                dir_up, nxt_dir;
  logic [CODE_W-1:0]   code, nxt_code, start_code, best_v, mep_q, fin_code;
  logic [CNT_W-1:0]    best_n;

  // named events
  logic accept_start, meas_evt, enter_settle, finish, take_best, run_step;
  logic better, settled, at_min, at_max;

  assign accept_start = start && (state == ST_IDLE || state == ST_DONE);
  assign meas_evt     = meas_done && (state == ST_MEAS);
  assign at_min       = (code == LO);
  assign at_max       = (code == HI);

  mep_energy_cmp #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cmp (
    .cand_v(code), .cand_n(meas_count), .best_v(best_v), .best_n(best_n), .lower(better)
  );

  mep_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(enter_settle), .len(settle_len), .expired(settled)
  );

  always_comb begin
    nxt_code     = code;
    nxt_phase    = phase;
    nxt_dir      = dir_up;
    enter_settle = 1'b0;
    finish       = 1'b0;
    take_best    = 1'b0;
    run_step     = 1'b0;
    fin_code     = code;
    if (accept_start) begin
      nxt_phase    = PH_BASE;
      enter_settle = 1'b1;
    end else if (meas_evt) begin
      unique case (phase)
        PH_BASE: begin
          take_best = 1'b1;
          if (!at_min) begin
            nxt_code = code - 1'b1; nxt_phase = PH_FIRST; nxt_dir = 1'b0; enter_settle = 1'b1;
          end else if (!at_max) begin
            nxt_code = code + 1'b1; nxt_phase = PH_REV; nxt_dir = 1'b1; enter_settle = 1'b1;
          end else begin
            finish = 1'b1; fin_code = code;
          end
        end
        PH_FIRST: begin
          if (better) begin
            take_best = 1'b1;
            if (!at_min) begin
              nxt_code = code - 1'b1; nxt_phase = PH_RUN; enter_settle = 1'b1;
            end else begin
              finish = 1'b1; fin_code = code;
            end
          end else if (start_code != HI) begin
            nxt_code = start_code + 1'b1; nxt_phase = PH_REV; nxt_dir = 1'b1; enter_settle = 1'b1;
          end else begin
            finish = 1'b1; fin_code = start_code;
          end
        end
        PH_REV: begin
          if (better) begin
            take_best = 1'b1;
            if (!at_max) begin
              nxt_code = code + 1'b1; nxt_phase = PH_RUN; enter_settle = 1'b1;
            end else begin
              finish = 1'b1; fin_code = code;
            end
          end else begin
            finish = 1'b1; fin_code = start_code;
          end
        end
        default: begin
          if (better) begin
            take_best = 1'b1;
            if (dir_up ? !at_max : !at_min) begin
              nxt_code = dir_up ? code + 1'b1 : code - 1'b1;
              enter_settle = 1'b1;
              run_step = 1'b1;
            end else begin
              finish = 1'b1; fin_code = code;
            end
          end else begin
            finish = 1'b1; fin_code = best_v;
          end
        end
      endcase
      if (finish) nxt_code = fin_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= PH_BASE;
      dir_up     <= 1'b0;
      code       <= INIT;
      start_code <= INIT;
      best_v     <= INIT;
      best_n     <= '0;
      mep_q      <= INIT;
    end else begin
      code   <= nxt_code;
      phase  <= nxt_phase;
      dir_up <= nxt_dir;
      if (take_best) begin
        best_v <= code;
        best_n <= meas_count;
      end
      if (accept_start) start_code <= code;
      if (finish) mep_q <= fin_code;
      unique case (state)
        ST_IDLE, ST_DONE: if (accept_start) state <= ST_SETTLE;
        ST_SETTLE:        if (settled) state <= ST_MEAS;
        default:          if (meas_evt) state <= finish ? ST_DONE : ST_SETTLE;
      endcase
    end
  end

  assign vcode    = code;
  assign meas_req = (state == ST_MEAS);
  assign done     = (state == ST_DONE);
  assign mep_code = mep_q;

  // R7: supply code stays inside the allowed window
  assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode >= LO) && (vcode <= HI));
  // R3: request held until answered
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && !meas_done) |=> meas_req);
  // R3: code does not move while a measurement is pending
  assert_code_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> $stable(vcode));
  // R6: a continuing step moves exactly one code
  assert_run_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_step |=> (vcode == $past(vcode) + 1'b1) || (vcode == $past(vcode) - 1'b1));
  // R8: result and driven code agree once finished
  assert_done_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vcode == mep_code));
  // R8: no request outstanding when finished
  assert_done_noreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !meas_req);
endmodule

// File: tb/tb_mep_search.sv
module tb_mep_search;
  localparam int CODE_W = 4, CNT_W = 12, SETTLE_W = 4;
  localparam int LO = 4, HI = 10, INIT = 7;

  logic clk = 1'b0;
  logic rst_n, start, meas_done;
  logic [SETTLE_W-1:0] settle_len;
  logic [CNT_W-1:0] meas_count;
  logic [CODE_W-1:0] vcode, mep_code;
  logic meas_req, done;

  int checks = 0, errors = 0, cyc = 0;
  int exp_seq[0:31];
  int exp_len, exp_final;

  always #4 clk = ~clk;

  mep_search #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W),
               .CODE_MIN(LO), .CODE_MAX(HI), .INIT_CODE(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_len(settle_len),
    .meas_done(meas_done), .meas_count(meas_count), .vcode(vcode),
    .meas_req(meas_req), .done(done), .mep_code(mep_code));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // kind 0: parabola around m; 1: equal energy everywhere; 2: energy rises with code; 3: falls
  function automatic int ncount(input int kind, input int m, input int c);
    case (kind)
      0: return 3000 / (1 + (c - m) * (c - m));
      1: return 100 * c;
      2: return 500;
      default: return 10 * c * c;
    endcase
  endfunction

  function automatic real en(input int kind, input int m, input int c);
    return real'(c) / real'(ncount(kind, m, c));
  endfunction

  task automatic push(input int c);
    exp_seq[exp_len] = c;
    exp_len++;
  endtask

  task automatic walk(input int kind, input int m, input int dir, input int from);
    int c = from;
    forever begin
      if ((dir < 0 && c == LO) || (dir > 0 && c == HI)) begin exp_final = c; return; end
      push(c + dir);
      if (en(kind, m, c + dir) < en(kind, m, c)) c = c + dir;
      else begin exp_final = c; return; end
    end
  endtask

  task automatic build_expect(input int kind, input int m, input int c0);
    exp_len = 0;
    push(c0);
    if (c0 > LO) begin
      push(c0 - 1);
      if (en(kind, m, c0 - 1) < en(kind, m, c0)) begin walk(kind, m, -1, c0 - 1); return; end
    end
    if (c0 < HI) begin
      push(c0 + 1);
      if (en(kind, m, c0 + 1) < en(kind, m, c0)) begin walk(kind, m, 1, c0 + 1); return; end
    end
    exp_final = c0;
  endtask

  task automatic run_search(input int kind, input int m, input int slen, input int lat, input bit poke);
    int k, idx;
    build_expect(kind, m, int'(vcode));
    settle_len = SETTLE_W'(slen);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    idx = 0;
    forever begin
      while (!meas_req && !done && k < 4000) begin @(negedge clk); k++; end
      if (k >= 4000) begin chk(1'b0, "R3 no response", k, slen + 2); return; end
      if (done) break;
      chk(k == slen + 2, "R3 settle to request", k, slen + 2);
      chk(idx < exp_len && int'(vcode) == exp_seq[idx], (idx < 2) ? "R2 probe code" : "R6 walk code",
          int'(vcode), (idx < exp_len) ? exp_seq[idx] : -1);
      chk(int'(vcode) >= LO && int'(vcode) <= HI, "R7 code in range", int'(vcode), LO);
      idx++;
      for (int j = 0; j < lat; j++) begin
        @(negedge clk);
        if (poke && j == 0) start = 1'b1; else start = 1'b0;
      end
      start = 1'b0;
      meas_done = 1'b1;
      meas_count = CNT_W'(ncount(kind, m, int'(vcode)));
      @(negedge clk);
      meas_done = 1'b0;
      k = 1;
    end
    chk(idx == exp_len, "R5 number of measurements", idx, exp_len);
    chk(int'(mep_code) == exp_final, (kind == 1) ? "R4 tie result" : "R8 result code", int'(mep_code), exp_final);
    chk(int'(vcode) == exp_final, "R6 code returned to result", int'(vcode), exp_final);
    chk(!meas_req, "R8 no request when done", int'(meas_req), 0);
    if (poke) chk(int'(mep_code) == exp_final, "R9 start ignored mid-search", int'(mep_code), exp_final);
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; meas_done = 1'b0; meas_count = '0; settle_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(vcode) == INIT, "R1 reset code", int'(vcode), INIT);
    chk(int'(mep_code) == INIT, "R1 reset result", int'(mep_code), INIT);
    chk(!meas_req && !done, "R1 reset flags", int'({meas_req, done}), 0);
    for (int i = 0; i < 18; i++) run_search(0, i - 2, i % 4, 1 + i % 3, i % 2 == 1);
    run_search(1, 0, 2, 1, 1'b0);   // R4 equal energy: stays put
    run_search(2, 0, 0, 2, 1'b0);   // R7 rising energy: walks to lower limit
    run_search(2, 0, 3, 1, 1'b1);   // R7 start at lower limit
    run_search(1, 0, 1, 3, 1'b0);   // R5 tie at lower limit
    run_search(3, 0, 5, 1, 1'b0);   // R7 falling energy: reverses and climbs to upper limit
    run_search(3, 0, 0, 1, 1'b0);   // R5 start at upper limit, reversal impossible
    run_search(0, 7, 15, 4, 1'b0);  // R2 long settle
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule